// File: doc/BRIEF.md
# Timer Interrupt Status and Line Router

This block sits behind a bank of event timers and turns their single-cycle fire events into interrupt status bits and interrupt lines. Each timer is either level-type, in which case a fire latches a status bit that holds its line high until software clears the bit, or edge-type, in which case the fire produces a one-cycle pulse on its line and leaves no status behind. A per-timer enable and a global enable gate what reaches the lines, while status keeps updating regardless of either enable.

Each timer picks one of the interrupt lines through a route field, and all timers that share a line are ORed onto it. A legacy replacement mode takes timers 0 and 1 away from their route fields and places them on lines 0 and 8. Outside that mode those two lines carry two external legacy interrupt inputs straight through, and a legacy-timer-enable output tells the external legacy timer that it owns its line. A timer can instead be set to signal by message: a fire then raises a one-cycle write request whose address and data come from that timer's message target word, and the timer drives no line.

Top module: `tirq_router`

## Requirements
- R1: A fire on a level-type timer sets its status bit at the next clock edge; a fire on an edge-type timer leaves its status bit at 0 after that edge.
- R2: A timer affects its line only while both its own enable and the global enable are 1; status bits update on fire whatever the enables are, and an edge-type fire while either enable is 0 produces no pulse.
- R3: A level-type timer with status set holds its line high for as long as the status bit stays set; an edge-type fire raises its line for exactly the one cycle after the fire edge.
- R4: A status write clears, at the next edge, every status bit whose data bit is 1 and drops the line that bit held; data bits of 0 leave their status bits unchanged. A fire in the same cycle wins over the clear.
- R5: With legacy mode on, timer 0 drives line 0 and timer 1 drives line 8 whatever their route fields; timers 2 and up always use their 5-bit route field as the line index.
- R6: With legacy mode off, the external legacy timer input is ORed onto line 0 and the external clock input onto line 8, and the legacy-timer-enable output is 1; with legacy mode on both inputs are blocked from the lines and the legacy-timer-enable output is 0.
- R7: Turning legacy mode off sets the legacy-timer-enable output back to 1 and line 8 at once follows the present level of the external clock input.
- R8: A fire of an enabled timer with its message bit set (and global enable 1) raises the message request for one cycle after the fire edge, with address equal to bits 63:32 and data equal to bits 31:0 of that timer's target word; when several fire together the lowest-numbered timer wins; a message-mode timer drives no line.
- R9: Turning a timer from level-type to edge-type clears its status bit at the next edge and drops its line at once; setting the timer enable or the global enable while the status bit is set raises the line at once.
- R10: Each interrupt line is the OR of every timer routed to it and of any pass-through input on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy replacement routing on |
| tmr_fire | input | NUM_TIMERS | One-cycle fire event per timer |
| tmr_en | input | NUM_TIMERS | Per-timer interrupt enable |
| tmr_level | input | NUM_TIMERS | 1 = level-type, 0 = edge-type |
| tmr_msg_en | input | NUM_TIMERS | Signal by message write instead of a line |
| tmr_route | input | NUM_TIMERS*5 | Line index per timer, timer i at bits 5i+4:5i |
| tmr_msg_target | input | NUM_TIMERS*64 | Message target per timer, address high, data low |
| sts_wr | input | 1 | Status write strobe |
| sts_wr_data | input | NUM_TIMERS | Write-one-to-clear mask |
| ext_pit_irq | input | 1 | External legacy timer interrupt input |
| ext_rtc_irq | input | 1 | External clock interrupt input |
| irq_lines | output | 32 | Interrupt lines |
| pit_enable | output | 1 | External legacy timer owns its line |
| tmr_status | output | NUM_TIMERS | Interrupt status bits |
| msg_valid | output | 1 | One-cycle message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions take for granted that a fire event lasts one cycle, that the clear mask is only looked at while the status write strobe is high, and that the type, enable and message bits are steady around each clock edge rather than toggling within a cycle. The stimulus changes every input just after a rising edge, drives fire and status writes as one-cycle strobes, and changes configuration bits only on cycles between fires, so each property sees the input shape it expects.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // Fixed line indices taken over by timers 0 and 1 in legacy mode
  localparam int unsigned LEG_LINE_T0 = 0;
  localparam int unsigned LEG_LINE_T1 = 8;
endpackage

// File: rtl/tirq_tmr_status.sv
module tirq_tmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic level,
  input  logic en,
  input  logic glb_en,
  input  logic msg_en,
  input  logic clr,
  output logic status,
  output logic line_req,
  output logic msg_elig
);
  logic lvl_q, status_q, pulse_q;
  logic gate_ok, lvl_drop;

  assign gate_ok  = en & glb_en;
  assign lvl_drop = lvl_q & ~level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      lvl_q   <= level;
      pulse_q <= fire & ~level & gate_ok & ~msg_en;
      if (fire)          status_q <= level;
      else if (lvl_drop) status_q <= 1'b0;
      else if (clr)      status_q <= 1'b0;
    end
  end

  assign status   = status_q;
  assign line_req = (status_q & level & gate_ok & ~msg_en) | pulse_q;
  assign msg_elig = fire & gate_ok & msg_en;

  p_level_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && level |=> status_q);
  p_edge_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !level |=> !status_q);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && glb_en) |=> !pulse_q);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q && !fire |=> !pulse_q);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !fire |=> !status_q);
  p_lvl_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q && !level && !fire |=> !status_q);
endmodule

// File: rtl/tirq_line_router.sv
module tirq_line_router #(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned NUM_LINES  = 32,
  localparam int unsigned RW        = $clog2(NUM_LINES)
) (
  input  logic                     legacy_mode,
  input  logic [NUM_TIMERS*RW-1:0] route_flat,
  input  logic [NUM_TIMERS-1:0]    line_req,
  input  logic                     ext_pit_irq,
  input  logic                     ext_rtc_irq,
  output logic [NUM_LINES-1:0]     lines
);
  import tirq_pkg::*;

  function automatic logic [RW-1:0] target_of(input int unsigned idx,
                                               input logic legacy,
                                               input logic [RW-1:0] route);
    if (legacy && idx == 0) return RW'(LEG_LINE_T0);
    if (legacy && idx == 1) return RW'(LEG_LINE_T1);
    return route;
  endfunction

  always_comb begin
    lines = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (line_req[i])
        lines[target_of(i, legacy_mode, route_flat[i*RW +: RW])] = 1'b1;
    end
    if (!legacy_mode) begin
      lines[LEG_LINE_T0] = lines[LEG_LINE_T0] | ext_pit_irq;
      lines[LEG_LINE_T1] = lines[LEG_LINE_T1] | ext_rtc_irq;
    end
  end
endmodule

// File: rtl/tirq_msg_arb.sv
module tirq_msg_arb #(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned TW        = ADDR_W + DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_TIMERS-1:0]    elig,
  input  logic [NUM_TIMERS*TW-1:0] targets,
  output logic                     msg_valid,
  output logic [ADDR_W-1:0]        msg_addr,
  output logic [DATA_W-1:0]        msg_data
);
  logic          sel_valid;
  logic [TW-1:0] sel_tgt;

  always_comb begin
    sel_valid = 1'b0;
    sel_tgt   = '0;
    for (int i = NUM_TIMERS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel_valid = 1'b1;
        sel_tgt   = targets[i*TW +: TW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= sel_valid;
      if (sel_valid) begin
        msg_addr <= sel_tgt[TW-1:DATA_W];
        msg_data <= sel_tgt[DATA_W-1:0];
      end
    end
  end

  p_msg_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|elig) |=> !msg_valid);
  p_msg_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |=> msg_valid);
endmodule

// File: rtl/tirq_router.sv
module tirq_router #(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned RW        = $clog2(NUM_LINES),
  localparam int unsigned TW        = ADDR_W + DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     glb_en,
  input  logic                     legacy_mode,
  input  logic [NUM_TIMERS-1:0]    tmr_fire,
  input  logic [NUM_TIMERS-1:0]    tmr_en,
  input  logic [NUM_TIMERS-1:0]    tmr_level,
  input  logic [NUM_TIMERS-1:0]    tmr_msg_en,
  input  logic [NUM_TIMERS*RW-1:0] tmr_route,
  input  logic [NUM_TIMERS*TW-1:0] tmr_msg_target,
  input  logic                     sts_wr,
  input  logic [NUM_TIMERS-1:0]    sts_wr_data,
  input  logic                     ext_pit_irq,
  input  logic                     ext_rtc_irq,
  output logic [NUM_LINES-1:0]     irq_lines,
  output logic                     pit_enable,
  output logic [NUM_TIMERS-1:0]    tmr_status,
  output logic                     msg_valid,
  output logic [ADDR_W-1:0]        msg_addr,
  output logic [DATA_W-1:0]        msg_data
);
  logic [NUM_TIMERS-1:0] line_req;
  logic [NUM_TIMERS-1:0] msg_elig;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    tirq_tmr_status u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (tmr_fire[g]),
      .level    (tmr_level[g]),
      .en       (tmr_en[g]),
      .glb_en   (glb_en),
      .msg_en   (tmr_msg_en[g]),
      .clr      (sts_wr & sts_wr_data[g]),
      .status   (tmr_status[g]),
      .line_req (line_req[g]),
      .msg_elig (msg_elig[g])
    );
  end

  tirq_line_router #(.NUM_TIMERS(NUM_TIMERS), .NUM_LINES(NUM_LINES)) u_route (
    .legacy_mode (legacy_mode),
    .route_flat  (tmr_route),
    .line_req    (line_req),
    .ext_pit_irq (ext_pit_irq),
    .ext_rtc_irq (ext_rtc_irq),
    .lines       (irq_lines)
  );

  tirq_msg_arb #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_msg (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (msg_elig),
    .targets   (tmr_msg_target),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

  assign pit_enable = ~legacy_mode;
endmodule

// File: tb/tirq_router_tb.sv
module tirq_router_tb;
  localparam int NT = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, glb_en, legacy_mode, sts_wr, ext_pit_irq, ext_rtc_irq;
  logic [NT-1:0]   tmr_fire, tmr_en, tmr_level, tmr_msg_en, sts_wr_data;
  logic [NT*5-1:0] tmr_route;
  logic [NT*64-1:0] tmr_msg_target;
  logic [31:0]     irq_lines, msg_addr, msg_data;
  logic            pit_enable, msg_valid;
  logic [NT-1:0]   tmr_status;

  tirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_mode(legacy_mode),
    .tmr_fire(tmr_fire), .tmr_en(tmr_en), .tmr_level(tmr_level),
    .tmr_msg_en(tmr_msg_en), .tmr_route(tmr_route), .tmr_msg_target(tmr_msg_target),
    .sts_wr(sts_wr), .sts_wr_data(sts_wr_data), .ext_pit_irq(ext_pit_irq),
    .ext_rtc_irq(ext_rtc_irq), .irq_lines(irq_lines), .pit_enable(pit_enable),
    .tmr_status(tmr_status), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  typedef struct {
    string       tag;
    logic [31:0] lines;
    logic [NT-1:0] sts;
    logic        pit;
    logic        mv;
    logic [31:0] ma;
    logic [31:0] md;
  } exp_t;

  exp_t sb_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // monitor: compares queued expectations away from the rising edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (irq_lines !== e.lines || tmr_status !== e.sts || pit_enable !== e.pit ||
          msg_valid !== e.mv || (e.mv && (msg_addr !== e.ma || msg_data !== e.md))) begin
        bad++;
        $display("FAIL %s: lines=%h sts=%b pit=%b mv=%b addr=%h data=%h | expected lines=%h sts=%b pit=%b mv=%b addr=%h data=%h",
                 e.tag, irq_lines, tmr_status, pit_enable, msg_valid, msg_addr, msg_data,
                 e.lines, e.sts, e.pit, e.mv, e.ma, e.md);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    tmr_fire = '0;
    sts_wr   = 1'b0;
  endtask

  task automatic expect_st(input string tag, input logic [31:0] l, input logic [NT-1:0] s,
                           input logic p, input logic mv = 1'b0,
                           input logic [31:0] ma = '0, input logic [31:0] md = '0);
    exp_t e;
    e.tag = tag; e.lines = l; e.sts = s; e.pit = p; e.mv = mv; e.ma = ma; e.md = md;
    sb_q.push_back(e);
    @(negedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; glb_en = 1; legacy_mode = 0; sts_wr = 0; sts_wr_data = '0;
    ext_pit_irq = 0; ext_rtc_irq = 0;
    tmr_fire = '0; tmr_en = 4'b1111; tmr_level = 4'b0101; tmr_msg_en = '0;
    tmr_route = {5'd5, 5'd5, 5'd4, 5'd3};
    tmr_msg_target = {32'hA000_0020, 32'h0000_00C3, 32'hA000_0010, 32'h0000_00C2,
                      64'h0, 64'h0};
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;
    expect_st("R6 reset state", 32'h0, 4'b0000, 1'b1);

    // R1 / R3 level timer 0 on route 3
    tmr_fire = 4'b0001; tick(); expect_st("R1 level fire sets status", 32'h8, 4'b0001, 1);
    tick(); expect_st("R3 level line held", 32'h8, 4'b0001, 1);
    // R3 edge timer 1 on route 4
    tmr_fire = 4'b0010; tick(); expect_st("R3 edge pulse, R1 edge no status", 32'h18, 4'b0001, 1);
    tick(); expect_st("R3 edge pulse one cycle", 32'h8, 4'b0001, 1);
    // R4 write-one-to-clear
    sts_wr = 1; sts_wr_data = 4'b0000; tick(); expect_st("R4 zero write no effect", 32'h8, 4'b0001, 1);
    sts_wr = 1; sts_wr_data = 4'b0001; tick(); expect_st("R4 one write clears", 32'h0, 4'b0000, 1);
    // R10 shared line 5 from timers 2 and 3
    tmr_fire = 4'b1100; tick(); expect_st("R10 shared line OR", 32'h20, 4'b0100, 1);
    tick(); expect_st("R10 level keeps shared line", 32'h20, 4'b0100, 1);
    sts_wr = 1; sts_wr_data = 4'b0100; tick(); expect_st("R4 clear timer 2", 32'h0, 4'b0000, 1);
    // R2 / R9 enables
    tmr_en = 4'b1110; tmr_fire = 4'b0001; tick();
    expect_st("R2 status set while disabled", 32'h0, 4'b0001, 1);
    tmr_en = 4'b1111; expect_st("R9 timer enable reasserts", 32'h8, 4'b0001, 1);
    glb_en = 0; expect_st("R2 global enable gates line", 32'h0, 4'b0001, 1);
    glb_en = 1; expect_st("R9 global enable reasserts", 32'h8, 4'b0001, 1);
    tmr_level = 4'b0100; tick(); expect_st("R9 level to edge clears", 32'h0, 4'b0000, 1);
    tmr_level = 4'b0101; tick();
    glb_en = 0; tmr_fire = 4'b0010; tick(); expect_st("R2 edge pulse gated", 32'h0, 4'b0000, 1);
    glb_en = 1;
    // R6 / R5 / R7 legacy
    ext_pit_irq = 1; ext_rtc_irq = 1;
    expect_st("R6 pass-through lines 0 and 8", 32'h101, 4'b0000, 1);
    legacy_mode = 1; expect_st("R6 legacy blocks inputs", 32'h0, 4'b0000, 0);
    tmr_fire = 4'b0011; tick(); expect_st("R5 legacy remap timers 0 and 1", 32'h101, 4'b0001, 0);
    tick(); expect_st("R5 timer 0 held on line 0", 32'h1, 4'b0001, 0);
    tmr_fire = 4'b0100; tick(); expect_st("R5 timer 2 keeps route", 32'h21, 4'b0101, 0);
    sts_wr = 1; sts_wr_data = 4'b0101; tick(); expect_st("R4 clear in legacy", 32'h0, 4'b0000, 0);
    ext_rtc_irq = 0; expect_st("R6 legacy still blocks", 32'h0, 4'b0000, 0);
    legacy_mode = 0; expect_st("R7 leave legacy restores", 32'h1, 4'b0000, 1);
    ext_rtc_irq = 1; expect_st("R7 line 8 follows input", 32'h101, 4'b0000, 1);
    ext_pit_irq = 0; ext_rtc_irq = 0;
    // R8 message mode
    tmr_msg_en = 4'b1100;
    tmr_fire = 4'b1000; tick();
    expect_st("R8 message from timer 3", 32'h0, 4'b0000, 1, 1, 32'hA000_0020, 32'h0000_00C3);
    tick(); expect_st("R8 message one cycle", 32'h0, 4'b0000, 1);
    tmr_fire = 4'b1100; tick();
    expect_st("R8 lowest timer wins", 32'h0, 4'b0100, 1, 1, 32'hA000_0010, 32'h0000_00C2);
    tick(); expect_st("R8 no line for message timer", 32'h0, 4'b0100, 1);

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule